// File: doc/BRIEF.md
# Transmit Timing Source Selector with Automatic Failover

This block chooses which timing reference paces a T1/E1 transmit framer. There are three candidates: the clock recovered from the receive line, the serial input clock that comes with transmit data, and a local clock derived from the master clock. Each one reaches the block as a one-cycle tick strobe in a single fast system clock domain. A 2-bit select field picks the candidate. The block then emits one registered tick stream, a code for the source now driving it, and a flag that is high while a failover is in effect.

When clock-loss protection is enabled and the line clock is selected, the block watches the recovered ticks. If the ticks stop for a whole window, the block moves to the local clock. It returns to the line clock by itself once enough closely spaced recovered ticks have arrived again. A sync-enable input asks for frame alignment to the 8 kHz reference. That request is passed on only while the local clock drives the transmit side.

A change of source takes effect on a tick of the new source. From the moment the change is requested until that tick, the old source's ticks are no longer passed on.

Top module: `tx_timing_sel`

## Requirements
- R1: With select code 00 and no failover, the active-source code is 00 (line) and tick_o repeats line_tick_i.
- R2: With select code 01, the active-source code is 01 (serial) and tick_o repeats ser_tick_i.
- R3: With select code 10, the active-source code is 10 (local) and tick_o repeats loc_tick_i.
- R4: Select code 11 behaves exactly like code 00 and chooses the line source.
- R5: Line loss is declared after LOSS_WIN consecutive system clocks with no line tick. If protection is enabled and code 00 or 11 is selected, the block then moves to the local source and failover_o goes high.
- R6: While line loss is declared, a run of REGAIN_TICKS line ticks clears the loss. Each tick in the run must follow the previous one within fewer than LOSS_WIN clocks. When the loss clears, the block returns to the line source and failover_o goes low. A tick that arrives after a gap of LOSS_WIN clocks or more starts a new run.
- R7: With protection disabled, line loss causes no switch: the active code stays 00 and tick_o stays low while line ticks are absent.
- R8: failover_o is high exactly when, in the previous cycle, protection was enabled, code 00 or 11 was selected and line loss was declared. Selecting code 01 or 10 clears the flag.
- R9: The active-source code changes only in a cycle in which tick_o is high. That tick is the first tick of the new source. While a switch is pending, tick_o stays low.
- R10: sync8k_act_o is high only when sync8k_en_i was high and the active source is local (code 10). It stays low with either of the other sources.
- R11: After reset, tick_o, failover_o and sync8k_act_o are low and the active-source code is 00. Code 11 never appears on active_src_o.
- R12: tick_o follows the input tick of the chosen source with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick_i | input | 1 | Recovered receive line clock tick |
| ser_tick_i | input | 1 | Transmit serial input clock tick |
| loc_tick_i | input | 1 | Local clock tick derived from the master clock |
| src_sel_i | input | 2 | Source select: 00/11 line, 01 serial, 10 local |
| loss_prot_en_i | input | 1 | Enables automatic failover on line clock loss |
| sync8k_en_i | input | 1 | Requests 8 kHz frame-sync alignment |
| tick_o | output | 1 | Selected transmit timing tick, registered |
| active_src_o | output | 2 | Active source code: 00 line, 01 serial, 10 local |
| failover_o | output | 1 | High while the local clock replaces a lost line clock |
| sync8k_act_o | output | 1 | 8 kHz alignment in effect (local source only) |

## Verification
A wrong loss or regain count shows up as a failover that starts or ends a few cycles early or late. A cycle-exact reference therefore catches it on the first cycle that failover_o or active_src_o differs, LOSS_WIN clocks after the line ticks stop. A faulty switching rule shows up as an extra tick, a missing tick or a source change in a cycle where tick_o is low, and it is visible in the very cycle of the switch. Regain gaps longer than the window are exercised specifically, because a run counter that is not cleared would bring the line source back when it should not.

// File: rtl/tts_pkg.sv
package tts_pkg;
    typedef enum logic [1:0] {
        SRC_LINE = 2'b00,
        SRC_SER  = 2'b01,
        SRC_LOC  = 2'b10
    } src_e;
endpackage

// File: rtl/tts_loss_mon.sv
// Watches the recovered line ticks and keeps a loss indication with hysteresis.
module tts_loss_mon #(
    parameter int LOSS_WIN     = 32,
    parameter int REGAIN_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    output logic line_lost
);
    localparam int GW = $clog2(LOSS_WIN + 1);
    localparam int RW = $clog2(REGAIN_TICKS + 1);
    localparam logic [GW-1:0] WIN_V = GW'(LOSS_WIN);
    localparam logic [RW-1:0] RUN_V = RW'(REGAIN_TICKS);

    typedef struct packed {
        logic [GW-1:0] gap;   // clocks since last tick, saturating
        logic [RW-1:0] run;   // qualifying ticks seen while lost
        logic          lost;
    } mon_t;

    mon_t q, d;
    logic [RW-1:0] run_n;

    always_comb begin
        d     = q;
        run_n = q.run;
        if (line_tick) begin
            d.gap = '0;
            if (q.lost) begin
                run_n = (q.gap < WIN_V) ? q.run + 1'b1 : RW'(1);
                if (run_n == RUN_V) begin
                    d.lost = 1'b0;
                    d.run  = '0;
                end else begin
                    d.run = run_n;
                end
            end
        end else begin
            d.gap = (q.gap == WIN_V) ? q.gap : q.gap + 1'b1;
            if (d.gap == WIN_V) begin
                d.run  = '0;
                d.lost = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line_lost = q.lost;
endmodule

// File: rtl/tts_src_arb.sv
// Resolves the wanted source and hands over on a tick of the new source.
module tts_src_arb
    import tts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       prot_en,
    input  logic       sync_en,
    input  logic       line_lost,
    input  logic       line_tick,
    input  logic       ser_tick,
    input  logic       loc_tick,
    output logic       tick_out,
    output src_e       act_out,
    output logic       fail_out,
    output logic       sync_out
);
    typedef struct packed {
        logic tick;
        src_e act;
        logic fail;
        logic sync;
    } arb_t;

    arb_t q, d;
    src_e want;
    logic fail_now;
    logic line_sel;

    function automatic logic tick_of(src_e s, logic lt, logic st, logic ot);
        case (s)
            SRC_SER: return st;
            SRC_LOC: return ot;
            default: return lt;
        endcase
    endfunction

    always_comb begin
        line_sel = (sel == 2'b00) || (sel == 2'b11);
        fail_now = prot_en && line_sel && line_lost;
        case (sel)
            2'b01:   want = SRC_SER;
            2'b10:   want = SRC_LOC;
            default: want = fail_now ? SRC_LOC : SRC_LINE;
        endcase

        d      = q;
        d.tick = 1'b0;
        if (want == q.act) begin
            d.tick = tick_of(q.act, line_tick, ser_tick, loc_tick);
        end else if (tick_of(want, line_tick, ser_tick, loc_tick)) begin
            d.tick = 1'b1;
            d.act  = want;
        end
        d.fail = fail_now;
        d.sync = sync_en && (d.act == SRC_LOC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.tick <= 1'b0;
            q.act  <= SRC_LINE;
            q.fail <= 1'b0;
            q.sync <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign tick_out = q.tick;
    assign act_out  = q.act;
    assign fail_out = q.fail;
    assign sync_out = q.sync;
endmodule

// File: rtl/tx_timing_sel.sv
module tx_timing_sel
    import tts_pkg::*;
#(
    parameter int LOSS_WIN     = 32,
    parameter int REGAIN_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_tick_i,
    input  logic       ser_tick_i,
    input  logic       loc_tick_i,
    input  logic [1:0] src_sel_i,
    input  logic       loss_prot_en_i,
    input  logic       sync8k_en_i,
    output logic       tick_o,
    output logic [1:0] active_src_o,
    output logic       failover_o,
    output logic       sync8k_act_o
);
    logic line_lost;
    src_e act;

    tts_loss_mon #(
        .LOSS_WIN    (LOSS_WIN),
        .REGAIN_TICKS(REGAIN_TICKS)
    ) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_tick(line_tick_i),
        .line_lost(line_lost)
    );

    tts_src_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (src_sel_i),
        .prot_en  (loss_prot_en_i),
        .sync_en  (sync8k_en_i),
        .line_lost(line_lost),
        .line_tick(line_tick_i),
        .ser_tick (ser_tick_i),
        .loc_tick (loc_tick_i),
        .tick_out (tick_o),
        .act_out  (act),
        .fail_out (failover_o),
        .sync_out (sync8k_act_o)
    );

    assign active_src_o = act;
endmodule

// File: rtl/tts_chk.sv
module tts_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       line_tick_i,
    input logic       ser_tick_i,
    input logic       loc_tick_i,
    input logic [1:0] src_sel_i,
    input logic       loss_prot_en_i,
    input logic       sync8k_en_i,
    input logic       tick_o,
    input logic [1:0] active_src_o,
    input logic       failover_o,
    input logic       sync8k_act_o
);
    // R11
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_src_o != 2'b11);

    // R9
    switch_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_src_o != $past(active_src_o)) |-> tick_o);

    // R1
    line_tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && active_src_o == 2'b00) |-> $past(line_tick_i));

    // R2
    ser_tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && active_src_o == 2'b01) |-> $past(ser_tick_i));

    // R3
    loc_tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && active_src_o == 2'b10) |-> $past(loc_tick_i));

    // R10
    sync_local_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync8k_act_o |-> (active_src_o == 2'b10 && $past(sync8k_en_i)));

    // R8
    fail_line_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        failover_o |-> ($past(loss_prot_en_i) &&
                        ($past(src_sel_i) == 2'b00 || $past(src_sel_i) == 2'b11)));
endmodule

bind tx_timing_sel tts_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_tick_i   (line_tick_i),
    .ser_tick_i    (ser_tick_i),
    .loc_tick_i    (loc_tick_i),
    .src_sel_i     (src_sel_i),
    .loss_prot_en_i(loss_prot_en_i),
    .sync8k_en_i   (sync8k_en_i),
    .tick_o        (tick_o),
    .active_src_o  (active_src_o),
    .failover_o    (failover_o),
    .sync8k_act_o  (sync8k_act_o)
);

// File: tb/tx_timing_sel_bench.sv
module tx_timing_sel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LOSS_WIN   = 32;
    localparam int REGAIN     = 4;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_tick = 1'b0, ser_tick = 1'b0, loc_tick = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       en = 1'b0, s8 = 1'b0;
    logic       tick_o, failover_o, sync8k_act_o;
    logic [1:0] active_src_o;

    int vectors = 0, errors = 0, cyc = 0;
    int line_per = 5, ser_per = 7, loc_per = 6;
    int lc = 0, sc = 2, oc = 4;
    string ph = "R11";
    bit done = 0;

    // reference model state
    int m_act = 0, quiet = 0, run = 0;
    bit m_tick = 0, m_fail = 0, m_sync = 0, lost = 0;

    tx_timing_sel #(.LOSS_WIN(LOSS_WIN), .REGAIN_TICKS(REGAIN)) u_tx_timing_sel (
        .clk(clk), .rst_n(rst_n),
        .line_tick_i(line_tick), .ser_tick_i(ser_tick), .loc_tick_i(loc_tick),
        .src_sel_i(sel), .loss_prot_en_i(en), .sync8k_en_i(s8),
        .tick_o(tick_o), .active_src_o(active_src_o),
        .failover_o(failover_o), .sync8k_act_o(sync8k_act_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // tick generators
    always @(negedge clk) begin
        lc++; sc++; oc++;
        line_tick = (line_per != 0) && (lc % line_per == 0);
        ser_tick  = (ser_per  != 0) && (sc % ser_per  == 0);
        loc_tick  = (loc_per  != 0) && (oc % loc_per  == 0);
    end

    // behavioural reference, updated on the same edge the design samples
    always @(posedge clk) begin
        int want;
        bit t [3];
        if (!rst_n) begin
            m_act = 0; m_tick = 0; m_fail = 0; m_sync = 0;
            quiet = 0; run = 0; lost = 0;
        end else begin
            t[0] = line_tick; t[1] = ser_tick; t[2] = loc_tick;
            if (sel == 2'b01)      want = 1;
            else if (sel == 2'b10) want = 2;
            else                   want = (en && lost) ? 2 : 0;
            if (want == m_act) m_tick = t[m_act];
            else if (t[want]) begin m_tick = 1; m_act = want; end
            else m_tick = 0;
            m_fail = en && (sel == 2'b00 || sel == 2'b11) && lost;
            m_sync = s8 && (m_act == 2);
            if (line_tick) begin
                if (lost) begin
                    run = (quiet < LOSS_WIN) ? run + 1 : 1;
                    if (run >= REGAIN) begin lost = 0; run = 0; end
                end
                quiet = 0;
            end else begin
                if (quiet < LOSS_WIN) quiet++;
                if (quiet == LOSS_WIN) begin run = 0; lost = 1; end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (tick_o !== m_tick) begin
                errors++;
                $display("FAIL R12 (%s) tick_o got %0b exp %0b at cycle %0d", ph, tick_o, m_tick, cyc);
            end
            vectors++;
            if (active_src_o !== 2'(m_act)) begin
                errors++;
                $display("FAIL %s active_src_o got %0d exp %0d at cycle %0d", ph, active_src_o, m_act, cyc);
            end
            vectors++;
            if (failover_o !== m_fail) begin
                errors++;
                $display("FAIL %s failover_o got %0b exp %0b at cycle %0d", ph, failover_o, m_fail, cyc);
            end
            vectors++;
            if (sync8k_act_o !== m_sync) begin
                errors++;
                $display("FAIL R10 (%s) sync8k_act_o got %0b exp %0b at cycle %0d", ph, sync8k_act_o, m_sync, cyc);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            errors++;
            done = 1;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic phase(input string tag, input logic [1:0] s, input logic e,
                         input logic y, input int n);
        ph = tag; sel = s; en = e; s8 = y;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R11: reset state is compared while reset is held and just after
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        phase("R1", 2'b00, 1'b0, 1'b0, 200);
        phase("R2", 2'b01, 1'b0, 1'b0, 200);
        phase("R3", 2'b10, 1'b0, 1'b1, 200);
        phase("R4", 2'b11, 1'b0, 1'b0, 200);
        phase("R10", 2'b00, 1'b0, 1'b1, 100);
        // R5: line ticks stop with protection on
        line_per = 0;
        phase("R5", 2'b00, 1'b1, 1'b1, 150);
        phase("R8", 2'b01, 1'b1, 1'b0, 100);
        phase("R5", 2'b11, 1'b1, 1'b0, 60);
        // R6: recovery returns
        line_per = 5;
        phase("R6", 2'b00, 1'b1, 1'b0, 200);
        // R6 corner: ticks too sparse to regain, then dense again
        line_per = 0;
        phase("R6", 2'b00, 1'b1, 1'b0, 60);
        line_per = 40;
        phase("R6", 2'b00, 1'b1, 1'b0, 300);
        line_per = 5;
        phase("R6", 2'b00, 1'b1, 1'b0, 150);
        // R7: protection disabled
        line_per = 0;
        phase("R7", 2'b00, 1'b0, 1'b0, 200);
        line_per = 5;
        phase("R7", 2'b00, 1'b0, 1'b0, 100);
        // R9: rapid reselection with loss events mixed in
        for (int i = 0; i < 30; i++) begin
            line_per = (i % 7 < 3) ? 0 : 5;
            phase("R9", 2'(i % 4), 1'(i % 2), 1'(i % 3 == 0), 13 + (i % 5) * 7);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule